// File: doc/BRIEF.md
# MMC Clock Rate Selector

This block turns a requested MMC/SD card clock frequency into the settings a clock generator needs. Those settings are a 2-bit source-select field and a 6-bit divider field. The block first tries to derive the clock from the general PLL. If the divider that would need does not fit, it falls back to the fixed 24 MHz oscillator. After writing both fields, it reports the frequency those fields actually produce, which may differ from the one requested.

A second, read-only strobe makes the block recompute the present frequency from the stored fields and the current PLL rate. Software therefore sees the live rate after the PLL has been reprogrammed. All divisions run through one shared serial restoring divider, so a request takes up to three divisions of 32 cycles each. Completion is signalled by a single-cycle `done_o` pulse. The block only computes settings; it does not divide any clock itself.

Top module: `clkrate_mmc_sel`

## Requirements
- R1: After reset, mux_o=0, div_o=0, rate_o=0, done_o=0 and err_o=0.
- R2: On a valid request with q = pll_rate_i / want_rate_i (integer) and q <= 64, mux_o becomes code 1 (general PLL) and div_o becomes (q - 2) modulo 64.
- R3: On a valid request with q > 64, mux_o becomes code 2 (oscillator) and div_o becomes (24000000 / want_rate_i - 2) modulo 64.
- R4: At the done_o pulse that ends a request, rate_o equals src / (div_o + 1), where src is 24000000 when mux_o is 2 and the sampled PLL rate otherwise. err_o is 0 at that pulse.
- R5: A request with want_rate_i = 0, or with want_rate_i > pll_rate_i, pulses done_o the cycle after it is taken. At that pulse err_o=1, and mux_o, div_o and rate_o keep their previous values.
- R6: A read strobe (rd_i) leaves mux_o and div_o unchanged. It pulses done_o with rate_o recomputed as in R4, using the pll_rate_i present when the strobe is taken, and with err_o=0.
- R7: Any mux code other than 2, including the reset value 0, is treated as the general PLL when a rate is reconstructed.
- R8: done_o is high for exactly one cycle per accepted operation. req_i and rd_i are ignored while an operation is in progress.
- R9: Boundaries: q = 64 stays on the PLL (div_o = 62). q = 65 moves to the oscillator. q = 1 wraps div_o to 63.
- R10: When req_i and rd_i are both high in the same idle cycle, the request is performed and the read is dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Start a set operation with the current pll_rate_i / want_rate_i |
| rd_i | input | 1 | Recompute rate_o from the stored fields |
| pll_rate_i | input | 32 | General PLL rate in Hz |
| want_rate_i | input | 32 | Requested clock rate in Hz |
| mux_o | output | 2 | Source field: 1 = general PLL, 2 = oscillator |
| div_o | output | 6 | Divider field; output rate = src / (div_o + 1) |
| rate_o | output | 32 | Achieved rate in Hz |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Last operation was rejected |

## Verification
The embedded assertions check the following on every cycle:
- done_o is a single-cycle pulse.
- The stored fields never move while the controller is idle.
- A rejected request leaves the rate untouched.
- The shared divider is never restarted while busy, never sees a zero divisor, and always finishes with a remainder smaller than the divisor.

The exact field encodings need the bench's scenarios to show them: the 64/65 quotient boundary, the modulo-64 wrap, the oscillator fallback, and a read-back that follows a changed PLL rate. The same holds for the request-over-read priority and for strobes dropped mid-operation.

// File: rtl/clkrate_pkg.sv
package clkrate_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_PLL, ST_OSC, ST_RATE} ctrl_st_e;
  localparam logic [1:0] MUX_GEN = 2'd1;
  localparam logic [1:0] MUX_OSC = 2'd2;
endpackage

// File: rtl/clkrate_divider.sv
module clkrate_divider #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic [W-1:0] dividend_i,
  input  logic [W-1:0] divisor_i,
  output logic         busy_o,
  output logic         done_o,
  output logic [W-1:0] quot_o
);
  localparam int CW = $clog2(W + 1);

  logic [W-1:0]  rem_q, quo_q, dvs_q;
  logic [CW-1:0] cnt_q;
  logic          done_q;
  logic [W:0]    rem_sh, rem_nx;
  logic          ge;

  always_comb begin
    rem_sh = {rem_q, quo_q[W-1]};
    ge     = rem_sh >= {1'b0, dvs_q};
    rem_nx = ge ? rem_sh - {1'b0, dvs_q} : rem_sh;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rem_q  <= '0;
      quo_q  <= '0;
      dvs_q  <= '0;
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start_i && cnt_q == '0) begin
        rem_q <= '0;
        quo_q <= dividend_i;
        dvs_q <= divisor_i;
        cnt_q <= CW'(W);
      end else if (cnt_q != '0) begin
        rem_q <= rem_nx[W-1:0];
        quo_q <= {quo_q[W-2:0], ge};
        cnt_q <= cnt_q - CW'(1);
        if (cnt_q == CW'(1)) done_q <= 1'b1;
      end
    end
  end

  assign busy_o = cnt_q != '0;
  assign done_o = done_q;
  assign quot_o = quo_q;

  p_no_restart_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> !busy_o);
  p_nonzero_divisor_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> divisor_i != '0);
  p_rem_bound_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> rem_q < dvs_q);
endmodule

// File: rtl/clkrate_ctrl.sv
module clkrate_ctrl
  import clkrate_pkg::*;
#(
  parameter int W        = 32,
  parameter int OSC_RATE = 24_000_000,
  parameter int FW       = 6
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic          rd_i,
  input  logic [W-1:0]  pll_rate_i,
  input  logic [W-1:0]  want_rate_i,
  input  logic          div_done_i,
  input  logic [W-1:0]  div_quot_i,
  output logic          div_start_o,
  output logic [W-1:0]  div_dvd_o,
  output logic [W-1:0]  div_dvs_o,
  output logic [1:0]    mux_o,
  output logic [FW-1:0] div_o,
  output logic [W-1:0]  rate_o,
  output logic          done_o,
  output logic          err_o
);
  localparam logic [W-1:0] OSC   = W'(OSC_RATE);
  localparam logic [W-1:0] Q_LIM = W'(1 << FW);

  ctrl_st_e      st_q, st_d;
  logic [W-1:0]  pll_q, want_q, rate_q, qm2;
  logic [1:0]    mux_q;
  logic [FW-1:0] fld_q, fld_new;
  logic          done_q, err_q, bad_req, ovf;

  always_comb begin
    bad_req     = (want_rate_i == '0) || (want_rate_i > pll_rate_i);
    qm2         = div_quot_i - W'(2);
    fld_new     = qm2[FW-1:0];
    ovf         = div_quot_i > Q_LIM;
    st_d        = st_q;
    div_start_o = 1'b0;
    div_dvd_o   = '0;
    div_dvs_o   = W'(1);
    unique case (st_q)
      ST_IDLE: begin
        if (req_i) begin
          if (!bad_req) begin
            div_start_o = 1'b1;
            div_dvd_o   = pll_rate_i;
            div_dvs_o   = want_rate_i;
            st_d        = ST_PLL;
          end
        end else if (rd_i) begin
          div_start_o = 1'b1;
          div_dvd_o   = (mux_q == MUX_OSC) ? OSC : pll_rate_i;
          div_dvs_o   = W'(fld_q) + W'(1);
          st_d        = ST_RATE;
        end
      end
      ST_PLL: if (div_done_i) begin
        div_start_o = 1'b1;
        if (ovf) begin
          div_dvd_o = OSC;
          div_dvs_o = want_q;
          st_d      = ST_OSC;
        end else begin
          div_dvd_o = pll_q;
          div_dvs_o = W'(fld_new) + W'(1);
          st_d      = ST_RATE;
        end
      end
      ST_OSC: if (div_done_i) begin
        div_start_o = 1'b1;
        div_dvd_o   = OSC;
        div_dvs_o   = W'(fld_new) + W'(1);
        st_d        = ST_RATE;
      end
      ST_RATE: if (div_done_i) st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      pll_q  <= '0;
      want_q <= '0;
      rate_q <= '0;
      mux_q  <= '0;
      fld_q  <= '0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      done_q <= 1'b0;
      unique case (st_q)
        ST_IDLE: if (req_i) begin
          pll_q  <= pll_rate_i;
          want_q <= want_rate_i;
          if (bad_req) begin
            done_q <= 1'b1;
            err_q  <= 1'b1;
          end
        end
        ST_PLL: if (div_done_i && !ovf) begin
          mux_q <= MUX_GEN;
          fld_q <= fld_new;
        end
        ST_OSC: if (div_done_i) begin
          mux_q <= MUX_OSC;
          fld_q <= fld_new;
        end
        ST_RATE: if (div_done_i) begin
          rate_q <= div_quot_i;
          done_q <= 1'b1;
          err_q  <= 1'b0;
        end
        default: ;
      endcase
    end
  end

  assign mux_o  = mux_q;
  assign div_o  = fld_q;
  assign rate_o = rate_q;
  assign done_o = done_q;
  assign err_o  = err_q;

  p_done_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q);
  p_fields_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_IDLE) |=> ($stable(mux_q) && $stable(fld_q)));
  p_zero_reject_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_IDLE && req_i && want_rate_i == '0) |=> (done_q && err_q));
  p_rate_keep_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_q && err_q) |-> $stable(rate_q));
  p_req_prio_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_IDLE && req_i && rd_i && !bad_req) |=> st_q == ST_PLL);
endmodule

// File: rtl/clkrate_mmc_sel.sv
module clkrate_mmc_sel #(
  parameter int W        = 32,
  parameter int OSC_RATE = 24_000_000,
  parameter int FW       = 6
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic          rd_i,
  input  logic [W-1:0]  pll_rate_i,
  input  logic [W-1:0]  want_rate_i,
  output logic [1:0]    mux_o,
  output logic [FW-1:0] div_o,
  output logic [W-1:0]  rate_o,
  output logic          done_o,
  output logic          err_o
);
  logic         dv_start, dv_busy, dv_done;
  logic [W-1:0] dv_dvd, dv_dvs, dv_quot;

  clkrate_ctrl #(.W(W), .OSC_RATE(OSC_RATE), .FW(FW)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_i       (req_i),
    .rd_i        (rd_i),
    .pll_rate_i  (pll_rate_i),
    .want_rate_i (want_rate_i),
    .div_done_i  (dv_done),
    .div_quot_i  (dv_quot),
    .div_start_o (dv_start),
    .div_dvd_o   (dv_dvd),
    .div_dvs_o   (dv_dvs),
    .mux_o       (mux_o),
    .div_o       (div_o),
    .rate_o      (rate_o),
    .done_o      (done_o),
    .err_o       (err_o)
  );

  clkrate_divider #(.W(W)) u_div (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (dv_start),
    .dividend_i (dv_dvd),
    .divisor_i  (dv_dvs),
    .busy_o     (dv_busy),
    .done_o     (dv_done),
    .quot_o     (dv_quot)
  );

  p_idle_done_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dv_done |-> !dv_busy);
endmodule

// File: tb/clkrate_mmc_sel_tb.sv
module clkrate_mmc_sel_tb;
  localparam logic [31:0] OSC = 32'd24_000_000;

  typedef struct {
    logic [1:0]  mux;
    logic [5:0]  fld;
    logic [31:0] rate;
    logic        err;
    string       tag;
  } exp_t;

  logic        clk = 1'b0, rst_n = 1'b0, req = 1'b0, rd = 1'b0;
  logic [31:0] pll = '0, want = '0;
  logic [1:0]  mux_o;
  logic [5:0]  div_o;
  logic [31:0] rate_o;
  logic        done_o, err_o;

  int   errs = 0, checks = 0, n_done = 0, target = 0;
  bit   finished = 0;
  exp_t sb[$];
  logic [1:0]  m_mux = 2'd0;
  logic [5:0]  m_fld = 6'd0;
  logic [31:0] m_rate = 32'd0;

  always #10 clk = ~clk;

  clkrate_mmc_sel u_dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .rd_i(rd),
    .pll_rate_i(pll), .want_rate_i(want),
    .mux_o(mux_o), .div_o(div_o), .rate_o(rate_o),
    .done_o(done_o), .err_o(err_o)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic exp_t model_set(input logic [31:0] p, input logic [31:0] w, input string tag);
    exp_t e;
    logic [31:0] q, t, src;
    if (w == 0 || w > p) begin
      e.err = 1'b1;
    end else begin
      q = p / w;
      if (q > 32'd64) begin
        t = OSC / w - 32'd2;
        m_mux = 2'd2;
        src = OSC;
      end else begin
        t = q - 32'd2;
        m_mux = 2'd1;
        src = p;
      end
      m_fld = t[5:0];
      m_rate = src / ({26'd0, m_fld} + 32'd1);
      e.err = 1'b0;
    end
    e.mux = m_mux; e.fld = m_fld; e.rate = m_rate; e.tag = tag;
    return e;
  endfunction

  function automatic exp_t model_read(input logic [31:0] p, input string tag);
    exp_t e;
    logic [31:0] src;
    src = (m_mux == 2'd2) ? OSC : p;
    m_rate = src / ({26'd0, m_fld} + 32'd1);
    e.mux = m_mux; e.fld = m_fld; e.rate = m_rate; e.err = 1'b0; e.tag = tag;
    return e;
  endfunction

  task automatic wait_done();
    target++;
    wait (n_done == target);
    @(negedge clk);
  endtask

  task automatic do_set(input logic [31:0] p, input logic [31:0] w, input string tag);
    sb.push_back(model_set(p, w, tag));
    @(negedge clk);
    pll = p; want = w; req = 1'b1;
    @(negedge clk);
    req = 1'b0;
    wait_done();
  endtask

  task automatic do_read(input logic [31:0] p, input string tag);
    sb.push_back(model_read(p, tag));
    @(negedge clk);
    pll = p; rd = 1'b1;
    @(negedge clk);
    rd = 1'b0;
    wait_done();
  endtask

  // monitor: pops scoreboard on each done pulse
  logic prev_done = 1'b0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_done && done_o) check(1'b0, "R8 done wider than one cycle", 32'd1, 32'd0);
      if (done_o) begin
        if (sb.size() == 0) begin
          check(1'b0, "R8 unexpected done", 32'd1, 32'd0);
        end else begin
          exp_t e;
          e = sb.pop_front();
          check(mux_o == e.mux, {e.tag, " mux"}, {30'd0, mux_o}, {30'd0, e.mux});
          check(div_o == e.fld, {e.tag, " div"}, {26'd0, div_o}, {26'd0, e.fld});
          check(rate_o == e.rate, {e.tag, " rate"}, rate_o, e.rate);
          check(err_o == e.err, {e.tag, " err"}, {31'd0, err_o}, {31'd0, e.err});
        end
        n_done++;
      end
      prev_done <= done_o;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(mux_o == 2'd0, "R1 reset mux", {30'd0, mux_o}, 32'd0);
    check(div_o == 6'd0, "R1 reset div", {26'd0, div_o}, 32'd0);
    check(rate_o == 32'd0, "R1 reset rate", rate_o, 32'd0);
    check(!done_o && !err_o, "R1 reset done/err", {30'd0, done_o, err_o}, 32'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    do_read(32'd600_000_000, "R7 read with reset mux code 0");
    do_set(32'd600_000_000, 32'd50_000_000, "R2 pll path q=12");
    do_set(32'd600_000_000, 32'd10_000_000, "R4 pll path q=60");
    do_set(32'd600_000_000, 32'd9_375_000, "R9 q=64 stays on pll");
    do_set(32'd600_000_000, 32'd9_230_769, "R9 q=65 goes to osc");
    do_set(32'd600_000_000, 32'd400_000, "R3 osc fallback 400k");
    do_set(32'd600_000_000, 32'd600_000_000, "R9 q=1 wraps to 63");
    do_set(32'd600_000_000, 32'd0, "R5 zero request rejected");
    do_set(32'd600_000_000, 32'd700_000_000, "R5 above source rejected");
    do_read(32'd300_000_000, "R6 read follows new pll");
    do_set(32'd300_000_000, 32'd400_000, "R3 osc fallback again");
    do_read(32'd900_000_000, "R6 read keeps osc source");

    // R10: request wins over read in the same cycle
    sb.push_back(model_set(32'd800_000_000, 32'd25_000_000, "R10 req over rd"));
    @(negedge clk);
    pll = 32'd800_000_000; want = 32'd25_000_000; req = 1'b1; rd = 1'b1;
    @(negedge clk);
    req = 1'b0; rd = 1'b0;
    wait_done();

    // R8: strobes while busy are dropped
    sb.push_back(model_set(32'd500_000_000, 32'd20_000_000, "R8 busy ignore"));
    @(negedge clk);
    pll = 32'd500_000_000; want = 32'd20_000_000; req = 1'b1;
    @(negedge clk);
    req = 1'b0;
    repeat (5) @(negedge clk);
    want = 32'd100_000; req = 1'b1;
    @(negedge clk);
    req = 1'b0; rd = 1'b1;
    @(negedge clk);
    rd = 1'b0;
    wait_done();
    repeat (150) @(negedge clk);
    check(n_done == target, "R8 no extra done after busy strobes", n_done, target);
    check(sb.size() == 0, "R8 scoreboard drained", sb.size(), 32'd0);

    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    repeat (200_000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      check(1'b0, "watchdog expired", 32'd0, 32'd1);
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end
endmodule